// File: doc/BRIEF.md
# Wake Event and PME Controller

This block collects power-management wake sources from an Ethernet MAC and PHY and turns them into an active-low PCI power-management event pin and an internal wake interrupt. The MAC path carries a single wake pulse for either a magic packet or a wakeup frame. The PHY path carries an energy-detect pulse for a link status change. Each path has its own enable bit and its own sticky status bit. Any set status bit latches a PME status flag. That flag, gated by a PME enable bit, drives the pin from a register.

The block also chooses the mode the PHY enters after a reset: normal or general power-down. It decides from the power-state transition being taken, an auxiliary-power-present input and the PME enable. Software reaches the enables and status bits through a small write/read port. The status bits are write-one-to-clear.

There are two resets. The power-on reset clears everything. The functional reset clears only the source enables and the wakeup status bits. It keeps the PME enable, the PME status flag and the selected PHY mode.

Top module: `wake_pme_ctrl`

## Requirements
- R1: A MAC wake pulse sampled while the MAC enable (control bit 0, address 0) is 1 sets the MAC status bit (status bit 1, address 1) at that clock edge.
- R2: A PHY energy pulse sampled while the energy enable (control bit 1, address 0) is 1 sets the energy status bit (status bit 0, address 1) at that clock edge.
- R3: A wake pulse whose enable is 0 leaves both status bits and the PME status flag unchanged.
- R4: The PME status flag (status bit 2, address 1) becomes 1 on the clock edge after any wakeup status bit is seen set. `wake_irq` equals the PME status flag.
- R5: `pme_n` is registered. It is 0 in the cycle after an edge at which the PME status flag and the PME enable (control bit 2) were both 1, and 1 otherwise.
- R6: Writing 1 to a status bit at address 1 clears it, and writing 0 leaves it alone. An event or set condition on the same edge wins over the clear.
- R7: Power-on reset (`por_n` = 0) clears all state, drives `pme_n` to 1 and sets the PHY mode to normal. Functional reset (`func_rst_n` = 0) clears both source enables and both wakeup status bits, and keeps the PME enable, the PME status flag and the PHY mode.
- R8: When `pm_trans_valid` is 1, the PHY mode becomes power-down (`phy_pwrdn` = 1) for these combinations: transition code 6 with aux 1; code 1 or 3 with PME enable 0; code 10 or 11 with aux 1 and PME enable 0.
- R9: When `pm_trans_valid` is 1, the PHY mode becomes normal (`phy_pwrdn` = 0) for these combinations: transition code 9 with aux 0; code 5 with PME enable 0.
- R10: Any other transition code or input combination, and any cycle with `pm_trans_valid` = 0, leaves the PHY mode unchanged.
- R11: Reads are combinational. Address 0 returns the three control bits, address 1 returns the three status bits, address 2 returns the PHY mode in bit 0, and address 3 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| func_rst_n | input | 1 | Synchronous functional reset, active low |
| mac_wake_pulse | input | 1 | One-cycle MAC wake event (magic packet or wakeup frame) |
| phy_energy_pulse | input | 1 | One-cycle PHY energy-detect event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| pm_trans_valid | input | 1 | A power-state transition is taken this cycle |
| pm_trans_id | input | TRANS_W | Transition number (1 to 11) |
| aux_pwr_present | input | 1 | Auxiliary power detected |
| pme_n | output | 1 | Registered PME output, active low |
| wake_irq | output | 1 | Wake interrupt to the internal interrupt controller |
| phy_pwrdn | output | 1 | Selected PHY mode: 1 general power-down, 0 normal |

## Verification
The results arrive with fixed delays:

| Result | When it is due |
|---|---|
| A status bit | Visible on `reg_rdata` at the first clock edge after its pulse |
| PME status flag and `wake_irq` | One edge later than the status bit |
| `pme_n` | One more edge after the PME status flag |
| PHY mode | The edge at which the transition is sampled |

The bench applies inputs at the falling edge and lets exactly one rising edge pass before each comparison. It compares the outputs against a behavioural model that moves through these same latencies. Directed checks read the status and mode registers at those exact cycles. They also cover the event-over-clear collision and the retention across a functional reset.

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int TRANS_W = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               func_rst_n,
  input  logic               mac_wake_pulse,
  input  logic               phy_energy_pulse,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               pm_trans_valid,
  input  logic [TRANS_W-1:0] pm_trans_id,
  input  logic               aux_pwr_present,
  output logic               pme_n,
  output logic               wake_irq,
  output logic               phy_pwrdn
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);

  logic mac_en, nrg_en, pme_en;
  logic wus_mac, wus_nrg, pme_sts, pme_q, mode_q;
  logic wr_ctrl, wr_stat, mac_set, nrg_set;
  logic mode_hit, mode_val;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign mac_set = mac_wake_pulse && mac_en;
  assign nrg_set = phy_energy_pulse && nrg_en;

  always_ff @(posedge clk) begin
    if (!por_n || !func_rst_n) begin
      mac_en  <= 1'b0;
      nrg_en  <= 1'b0;
      wus_mac <= 1'b0;
      wus_nrg <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mac_en <= reg_wdata[0];
        nrg_en <= reg_wdata[1];
      end
      if (mac_set)                       wus_mac <= 1'b1;
      else if (wr_stat && reg_wdata[1])  wus_mac <= 1'b0;
      if (nrg_set)                       wus_nrg <= 1'b1;
      else if (wr_stat && reg_wdata[0])  wus_nrg <= 1'b0;
    end
  end

  always_comb begin
    mode_hit = 1'b0;
    mode_val = 1'b0;
    case (pm_trans_id)
      TRANS_W'(9):  begin mode_hit = !aux_pwr_present;             mode_val = 1'b0; end
      TRANS_W'(6):  begin mode_hit = aux_pwr_present;              mode_val = 1'b1; end
      TRANS_W'(1),
      TRANS_W'(3):  begin mode_hit = !pme_en;                      mode_val = 1'b1; end
      TRANS_W'(10),
      TRANS_W'(11): begin mode_hit = aux_pwr_present && !pme_en;   mode_val = 1'b1; end
      TRANS_W'(5):  begin mode_hit = !pme_en;                      mode_val = 1'b0; end
      default:      begin mode_hit = 1'b0;                         mode_val = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pme_en  <= 1'b0;
      pme_sts <= 1'b0;
      pme_q   <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      pme_q <= !(pme_sts && pme_en);
      if (func_rst_n) begin
        if (wr_ctrl) pme_en <= reg_wdata[2];
        if (wus_mac || wus_nrg)           pme_sts <= 1'b1;
        else if (wr_stat && reg_wdata[2]) pme_sts <= 1'b0;
        if (pm_trans_valid && mode_hit) mode_q <= mode_val;
      end
    end
  end

  assign pme_n     = pme_q;
  assign wake_irq  = pme_sts;
  assign phy_pwrdn = mode_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[2:0] = {pme_en, nrg_en, mac_en};
      A_STAT: reg_rdata[2:0] = {pme_sts, wus_mac, wus_nrg};
      A_MODE: reg_rdata[0]   = mode_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module wake_pme_chk #(
  parameter int TRANS_W = 4
) (
  input logic               clk,
  input logic               por_n,
  input logic               func_rst_n,
  input logic               mac_wake_pulse,
  input logic               phy_energy_pulse,
  input logic               mac_en,
  input logic               nrg_en,
  input logic               pme_en,
  input logic               wus_mac,
  input logic               wus_nrg,
  input logic               pme_sts,
  input logic               pme_n,
  input logic               pm_trans_valid,
  input logic [TRANS_W-1:0] pm_trans_id,
  input logic               aux_pwr_present,
  input logic               phy_pwrdn
);
  assert_mac_sets_R1: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (mac_wake_pulse && mac_en) |=> wus_mac);

  assert_nrg_sets_R2: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (phy_energy_pulse && nrg_en) |=> wus_nrg);

  assert_pme_latch_R4: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (wus_mac || wus_nrg) |=> pme_sts);

  assert_pme_pin_R5: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (pme_n == !($past(pme_sts) && $past(pme_en))));

  assert_mode_t9_R9: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (pm_trans_valid && pm_trans_id == TRANS_W'(9) && !aux_pwr_present) |=> !phy_pwrdn);

  assert_mode_t6_R8: assert property (@(posedge clk) disable iff (!por_n || !func_rst_n)
    (pm_trans_valid && pm_trans_id == TRANS_W'(6) && aux_pwr_present) |=> phy_pwrdn);

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    !pm_trans_valid |=> $stable(phy_pwrdn));
endmodule

bind wake_pme_ctrl wake_pme_chk #(.TRANS_W(TRANS_W)) chk_i (
  .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n),
  .mac_wake_pulse(mac_wake_pulse), .phy_energy_pulse(phy_energy_pulse),
  .mac_en(mac_en), .nrg_en(nrg_en), .pme_en(pme_en),
  .wus_mac(wus_mac), .wus_nrg(wus_nrg), .pme_sts(pme_sts), .pme_n(pme_n),
  .pm_trans_valid(pm_trans_valid), .pm_trans_id(pm_trans_id),
  .aux_pwr_present(aux_pwr_present), .phy_pwrdn(phy_pwrdn)
);

// File: tb/wake_pme_ctrl_tb.sv
`timescale 1ns/1ps
module wake_pme_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, func_rst_n = 1'b1;
  logic       mac_p = 1'b0, nrg_p = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic       tv = 1'b0;
  logic [3:0] tid = 4'd0;
  logic       aux = 1'b0;
  logic       pme_n, irq, pwrdn;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_pme_ctrl dut_i (
    .clk(clk), .por_n(por_n), .func_rst_n(func_rst_n),
    .mac_wake_pulse(mac_p), .phy_energy_pulse(nrg_p),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rd),
    .pm_trans_valid(tv), .pm_trans_id(tid), .aux_pwr_present(aux),
    .pme_n(pme_n), .wake_irq(irq), .phy_pwrdn(pwrdn)
  );

  // behavioural reference
  bit m_men, m_een, m_pen, m_smac, m_snrg, m_psts, m_pin = 1'b1, m_mode;

  always @(posedge clk) begin
    bit n_men, n_een, n_pen, n_smac, n_snrg, n_psts, n_pin, n_mode;
    n_men = m_men; n_een = m_een; n_pen = m_pen; n_smac = m_smac;
    n_snrg = m_snrg; n_psts = m_psts; n_mode = m_mode;
    n_pin = !(m_psts && m_pen);
    if (we && addr == 2'd0) begin n_men = wd[0]; n_een = wd[1]; n_pen = wd[2]; end
    if (we && addr == 2'd1) begin
      if (wd[0]) n_snrg = 0;
      if (wd[1]) n_smac = 0;
      if (wd[2]) n_psts = 0;
    end
    if (mac_p && m_men) n_smac = 1;
    if (nrg_p && m_een) n_snrg = 1;
    if (m_smac || m_snrg) n_psts = 1;
    if (tv) begin
      if (tid == 9 && !aux) n_mode = 0;
      else if (tid == 6 && aux) n_mode = 1;
      else if ((tid == 1 || tid == 3) && !m_pen) n_mode = 1;
      else if ((tid == 10 || tid == 11) && aux && !m_pen) n_mode = 1;
      else if (tid == 5 && !m_pen) n_mode = 0;
    end
    if (!por_n) begin
      m_men = 0; m_een = 0; m_pen = 0; m_smac = 0; m_snrg = 0;
      m_psts = 0; m_pin = 1; m_mode = 0;
    end else if (!func_rst_n) begin
      m_men = 0; m_een = 0; m_smac = 0; m_snrg = 0; m_pin = n_pin;
    end else begin
      m_men = n_men; m_een = n_een; m_pen = n_pen; m_smac = n_smac;
      m_snrg = n_snrg; m_psts = n_psts; m_pin = n_pin; m_mode = n_mode;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {5'd0, m_pen, m_een, m_men};
      2'd1: return {5'd0, m_psts, m_smac, m_snrg};
      2'd2: return {7'd0, m_mode};
      default: return 8'd0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    chk(pme_n == m_pin, "R5 pme_n", pme_n, m_pin);
    chk(irq == m_psts, "R4 wake_irq", irq, m_psts);
    chk(pwrdn == m_mode, "R10 phy_pwrdn", pwrdn, m_mode);
    chk(rd == m_read(addr), "R11 reg_rdata", rd, m_read(addr));
  endtask

  task automatic clr_in();
    mac_p = 0; nrg_p = 0; we = 0; tv = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1; addr = a; wd = d; step(); we = 0;
  endtask

  task automatic trans(input int t, input bit ax);
    tv = 1; tid = 4'(t); aux = ax; step(); tv = 0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    por_n = 1; step();
    addr = 2'd1; step();
    chk(rd == 8'h00 && pme_n && !pwrdn, "R7 reset state", rd, 0);

    wr(2'd0, 8'h07); addr = 2'd0; step();
    chk(rd == 8'h07, "R11 ctrl readback", rd, 7);

    addr = 2'd1; mac_p = 1; step(); mac_p = 0;
    chk(rd == 8'h02, "R1 mac status", rd, 2);
    step();
    chk(rd == 8'h06 && irq, "R4 pme status", rd, 6);
    step();
    chk(!pme_n, "R5 pme asserted", pme_n, 0);

    nrg_p = 1; step(); nrg_p = 0;
    chk(rd[0], "R2 energy status", rd, 7);

    we = 1; addr = 2'd1; wd = 8'h02; mac_p = 1; step(); we = 0; mac_p = 0;
    chk(rd[1], "R6 event beats clear", rd, 7);
    wr(2'd1, 8'h03); step();
    chk(rd[1:0] == 2'b00, "R6 w1c bits", rd[1:0], 0);
    wr(2'd1, 8'h04); step();
    chk(rd[2] == 1'b0, "R6 w1c pme", rd, 0);
    step();
    chk(pme_n, "R5 pme released", pme_n, 1);

    wr(2'd0, 8'h04);
    addr = 2'd1; mac_p = 1; nrg_p = 1; step(); clr_in(); step();
    chk(rd == 8'h00, "R3 disabled ignored", rd, 0);

    wr(2'd0, 8'h00);
    addr = 2'd2;
    trans(6, 1); chk(pwrdn, "R8 T6 aux1", pwrdn, 1);
    trans(9, 0); chk(!pwrdn, "R9 T9 aux0", pwrdn, 0);
    trans(3, 1); chk(pwrdn, "R8 T3 pme_en0", pwrdn, 1);
    trans(5, 0); chk(!pwrdn, "R9 T5 pme_en0", pwrdn, 0);
    trans(11, 1); chk(pwrdn, "R8 T11 aux1", pwrdn, 1);
    trans(9, 1); chk(pwrdn, "R10 T9 aux1 holds", pwrdn, 1);
    trans(7, 0); chk(pwrdn, "R10 T7 holds", pwrdn, 1);
    wr(2'd0, 8'h04);
    trans(5, 0); chk(pwrdn, "R10 T5 pme_en1 holds", pwrdn, 1);

    wr(2'd0, 8'h07); addr = 2'd1; nrg_p = 1; step(); nrg_p = 0; step(); step();
    func_rst_n = 0; step(); func_rst_n = 1; step();
    chk(rd == 8'h04, "R7 func reset keeps pme", rd, 4);
    addr = 2'd0; step();
    chk(rd == 8'h04, "R7 func reset clears enables", rd, 4);
    addr = 2'd2; step();
    chk(pwrdn, "R7 func reset keeps mode", pwrdn, 1);

    for (int i = 0; i < 4000; i++) begin
      mac_p = ($urandom_range(0, 7) == 0);
      nrg_p = ($urandom_range(0, 7) == 0);
      we    = ($urandom_range(0, 3) == 0);
      addr  = 2'($urandom_range(0, 3));
      wd    = 8'($urandom_range(0, 255));
      tv    = ($urandom_range(0, 3) == 0);
      tid   = 4'($urandom_range(0, 15));
      aux   = 1'($urandom_range(0, 1));
      func_rst_n = ($urandom_range(0, 63) != 0);
      por_n      = ($urandom_range(0, 511) != 0);
      step();
    end
    clr_in(); por_n = 1; func_rst_n = 1; step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule